// File: doc/BRIEF.md
# Loop Progress LED Driver

This block keeps a visible tally of how many passes a scrolling message has completed, using a row of active-high LEDs. Every loop-done pulse lights one more LED, filling the row from bit 0 upward like a thermometer. The full row marks the end of the run, and the message controller uses it to decide its next branch.

Once every LED is lit, the block reports completion on a dedicated flag and switches the LED row into a flicker effect. Each advance enable then flips the whole row between fully lit and fully dark. The completion flag comes from an internal saturated bit, not from the LED pattern, so the controller still sees "done" while the row is dark.

Top module: `loop_led_driver`

## Requirements
- R1: A high `rst` sampled at a rising clock edge clears `led_o` to all zeros and drops `all_done_o` to 0.
- R2: Before saturation, each cycle with `loop_done_i` high sets the next LED bit. After k pulses (k < LED_COUNT), `led_o` equals 2^k - 1, with bits k-1 down to 0 set.
- R3: On a cycle with neither `loop_done_i` nor `advance_i` high, `led_o` and `all_done_o` keep their values.
- R4: On the edge that takes the LED_COUNT-th pulse, `led_o` becomes all ones and `all_done_o` rises to 1.
- R5: After saturation, further `loop_done_i` pulses change neither `all_done_o` nor `led_o`.
- R6: While saturated, each cycle with `advance_i` high inverts `led_o`, switching it between all ones and all zeros. Saturation begins on all ones.
- R7: Before saturation, `advance_i` has no effect on `led_o`.
- R8: `all_done_o` stays at 1 through every flicker phase, including the all-zeros phase, until the next reset.
- R9: Reset is synchronous: raising `rst` between edges leaves `led_o` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loop_done_i | input | 1 | One pulse per completed message loop |
| advance_i | input | 1 | Step enable for the flicker effect |
| led_o | output | LED_COUNT | Active-high LED row |
| all_done_o | output | 1 | Saturated flag for the message controller |

## Verification
The fill is driven with both back-to-back and spaced pulses, which separates a true one-bit-per-pulse step from a design that skips or holds. Advance pulses are sent before saturation to show they are ignored, and after saturation to show the row flips. Saturated runs mix extra loop pulses with advance pulses, including both in the same cycle, so that a design clearing or refilling the row stands apart from one that only flickers. Resets arrive mid-fill and mid-flicker, and the LEDs are sampled between the reset request and the next edge to confirm the reset is synchronous.

// File: rtl/loop_led_pkg.sv
package loop_led_pkg;
  // Shift one more lit bit into a thermometer value.
  function automatic logic [31:0] thermo_step(input logic [31:0] v);
    return (v << 1) | 32'd1;
  endfunction
endpackage

// File: rtl/loop_fill_reg.sv
module loop_fill_reg #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [WIDTH-1:0] fill_o,
  output logic             sat_o
);
  import loop_led_pkg::*;
  localparam int LOWER = WIDTH - 1;

  logic [WIDTH-1:0] fill_q;
  logic             sat_q;
  logic [31:0]      widened;
  logic [31:0]      stepped;

  assign widened = 32'(fill_q);
  assign stepped = thermo_step(widened);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      sat_q  <= 1'b0;
    end else if (step_i && !sat_q) begin
      fill_q <= stepped[WIDTH-1:0];
      sat_q  <= &fill_q[LOWER-1:0];
    end
  end

  assign fill_o = fill_q;
  assign sat_o  = sat_q;
endmodule

// File: rtl/flicker_phase.sv
module flicker_phase (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic advance_i,
  output logic lit_o
);
  logic lit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lit_q <= 1'b1;
    end else if (enable_i && advance_i) begin
      lit_q <= ~lit_q;
    end
  end

  assign lit_o = lit_q;
endmodule

// File: rtl/loop_led_driver.sv
module loop_led_driver #(
  parameter int LED_COUNT = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 loop_done_i,
  input  logic                 advance_i,
  output logic [LED_COUNT-1:0] led_o,
  output logic                 all_done_o
);
  logic [LED_COUNT-1:0] fill;
  logic                 sat;
  logic                 lit;

  loop_fill_reg #(.WIDTH(LED_COUNT)) u_fill (
    .clk    (clk),
    .rst    (rst),
    .step_i (loop_done_i),
    .fill_o (fill),
    .sat_o  (sat)
  );

  flicker_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .enable_i  (sat),
    .advance_i (advance_i),
    .lit_o     (lit)
  );

  assign led_o      = sat ? {LED_COUNT{lit}} : fill;
  assign all_done_o = sat;
endmodule

module loop_led_checker #(
  parameter int LED_COUNT = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 loop_done_i,
  input logic                 advance_i,
  input logic [LED_COUNT-1:0] led_o,
  input logic                 all_done_o
);
  localparam logic [LED_COUNT-1:0] ONES = {LED_COUNT{1'b1}};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (led_o == '0) && !all_done_o);

  assert_thermometer_R2: assert property (@(posedge clk) disable iff (rst)
    !all_done_o |-> ((led_o & (led_o + 1'b1)) == '0));

  assert_fill_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!all_done_o && loop_done_i && (led_o != ONES)) |=>
      (led_o == (($past(led_o) << 1) | 1'b1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!loop_done_i && !advance_i) |=> ($stable(led_o) && $stable(all_done_o)));

  assert_done_full_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(all_done_o) |-> (led_o == ONES));

  assert_sticky_done_R8: assert property (@(posedge clk) disable iff (rst)
    all_done_o |=> all_done_o);

  assert_flicker_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (all_done_o && advance_i) |=> (led_o == ~$past(led_o)));

  assert_flicker_values_R6: assert property (@(posedge clk) disable iff (rst)
    all_done_o |-> ((led_o == ONES) || (led_o == '0)));

  assert_saturated_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (all_done_o && loop_done_i && !advance_i) |=> $stable(led_o));

  assert_early_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (!all_done_o && advance_i && !loop_done_i) |=> $stable(led_o));
endmodule

bind loop_led_driver loop_led_checker #(.LED_COUNT(LED_COUNT)) u_checker (
  .clk         (clk),
  .rst         (rst),
  .loop_done_i (loop_done_i),
  .advance_i   (advance_i),
  .led_o       (led_o),
  .all_done_o  (all_done_o)
);

// File: tb/loop_led_driver_bench.sv
module loop_led_driver_bench;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld  = 1'b0;
  logic         adv = 1'b0;
  logic [W-1:0] led;
  logic         done;

  int    checks = 0;
  int    fails  = 0;
  string req    = "R1";
  bit    finished = 0;

  // Reference model state.
  int cnt  = 0;
  bit msat = 0;
  bit mph  = 1;

  always #5 clk = ~clk;

  loop_led_driver #(.LED_COUNT(W)) u_loop_led_driver (
    .clk         (clk),
    .rst         (rst),
    .loop_done_i (ld),
    .advance_i   (adv),
    .led_o       (led),
    .all_done_o  (done)
  );

  function automatic logic [W-1:0] exp_led();
    if (msat) return mph ? {W{1'b1}} : '0;
    return W'((64'd1 << cnt) - 64'd1);
  endfunction

  task automatic check(string r, logic [W-1:0] act_led, logic act_done);
    checks++;
    if (act_led !== exp_led() || act_done !== msat) begin
      fails++;
      $display("FAIL %s: led=%b done=%b expected led=%b done=%b",
               r, act_led, act_done, exp_led(), msat);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      cnt = 0; msat = 0; mph = 1;
    end else if (!msat && ld) begin
      cnt++;
      if (cnt == W) msat = 1;
    end else if (msat && adv) begin
      mph = !mph;
    end
    #3;
    check(req, led, done);
  end

  task automatic drive(bit r, bit l, bit a, int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = r; ld = l; adv = a; req = tag;
    end
  endtask

  initial begin
    drive(1, 0, 0, 2, "R1");
    drive(0, 0, 0, 2, "R1");
    drive(0, 1, 0, 3, "R2");
    drive(0, 0, 0, 3, "R3");
    drive(0, 0, 1, 2, "R7");
    drive(0, 1, 1, 1, "R7");
    // R9: request reset between edges, LEDs unchanged before the edge
    @(negedge clk);
    rst = 1; ld = 0; adv = 0; req = "R9";
    #1 check("R9", led, done);
    drive(0, 0, 0, 1, "R1");
    for (int k = 0; k < W - 1; k++) begin
      drive(0, 1, 0, 1, "R2");
      drive(0, 0, 0, 1, "R3");
    end
    drive(0, 1, 0, 1, "R4");
    drive(0, 0, 0, 2, "R4");
    drive(0, 1, 0, 3, "R5");
    drive(0, 0, 1, 1, "R6");
    drive(0, 0, 0, 2, "R8");
    drive(0, 1, 0, 2, "R5");
    drive(0, 0, 1, 3, "R6");
    drive(0, 1, 1, 2, "R6");
    drive(0, 0, 0, 1, "R3");
    @(negedge clk);
    rst = 1; ld = 0; adv = 0; req = "R9";
    #1 check("R9", led, done);
    drive(0, 0, 0, 1, "R1");
    drive(0, 1, 0, W, "R4");
    drive(0, 1, 1, 4, "R6");
    drive(0, 0, 0, 2, "R8");
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule